// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the bus-facing half of a byte-wide SPI master. Software reaches it through a word-addressed register port with a valid/ready request and a read response one cycle later. The block keeps the control settings (clock mode, chip-select choice and polarity, transfer enable, interrupt enables), a clock divider, a transfer length, a hold value and a spare DMA-control word. It also holds a 16-entry transmit byte FIFO and a 16-entry receive byte FIFO.

The serial engine sits on the other side. It sees the head of the transmit FIFO and may take bytes only while transfer-active is set. It hands received bytes back and reports when it is idle. The block folds FIFO levels and engine idleness into a set of status flags that share the control word. It also drives one interrupt line built from two sources: transfer done and receive data waiting. Self-clearing flush bits in the control word empty either FIFO.

Top module: `spi_regfront`

## Requirements
- R1: After reset every stored register reads as zero, both FIFOs are empty, `irq` is 0 and `eng_tx_valid` is 0, so the word at 0x00 reads 0x0004_0000 (only TX-space set).
- R2: The control word at offset 0x00 stores these bits and reads them back: [1:0] chip select, [2] clock phase, [3] clock polarity, [6] active-high select, [7] transfer active (TA), [8] DMA enable, [9] done-interrupt enable, [10] RX-interrupt enable, [11] auto-deassert, [12] 3-wire read enable, [13] short-length mode, [23:21] per-line select polarity, [24] DMA length, [25] long length. Bits [5:4] always read 0, and the settings drive the matching engine outputs.
- R3: Writing 1 to control bit 4 empties the TX FIFO and writing 1 to bit 5 empties the RX FIFO; a flush wins over an engine push or pop in the same cycle.
- R4: A write to offset 0x04 pushes bits [7:0] into the TX FIFO (16 entries, first in first out), and a push to a full TX FIFO is dropped.
- R5: A read of offset 0x04 pops one RX byte (oldest first) into bits [7:0]. A read of an empty RX FIFO returns zero and changes nothing, and an engine push to a full RX FIFO is dropped.
- R6: The status bits of the word at 0x00 are [17] RX not empty, [18] TX not full, [19] RX holding 12 or more bytes, and [20] RX full (16 bytes).
- R7: Status bit [16] (DONE) is 1 exactly when TA is 1, the TX FIFO is empty and `eng_idle` is 1.
- R8: `irq` equals (bit 9 AND DONE) OR (bit 10 AND RX-needs-reading). Setting TA with an empty TX FIFO and an idle engine raises `irq` in the cycle TA becomes 1 when bit 9 is set.
- R9: The engine removes a TX byte only when `eng_tx_pop` is high while TA is 1. Clearing TA empties neither FIFO.
- R10: The clock divider (0x08), data length (0x0C) and hold (0x10) registers keep their low 16 bits and read 0 above. The DMA-control word (0x14) keeps all 32 bits. The divider and length drive `clk_div` and `xfer_len`.
- R11: `req_ready` is always 1. Each accepted read gives `rd_valid` and `rd_data` on the next cycle. Offsets 0x18 to 0x1C read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the word register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| eng_tx_data | output | 8 | Head of the TX FIFO |
| eng_tx_valid | output | 1 | TX FIFO not empty |
| eng_tx_pop | input | 1 | Engine takes the TX head |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_rx_push | input | 1 | Engine stores `eng_rx_data` |
| eng_idle | input | 1 | Engine has no byte in flight |
| xfer_active | output | 1 | TA setting |
| clk_pol | output | 1 | Clock polarity setting |
| clk_pha | output | 1 | Clock phase setting |
| cs_sel | output | 2 | Selected chip-select line |
| cs_act_high | output | 1 | Active-high select setting |
| cs_line_pol | output | 3 | Per-line select polarity |
| rd_enable_3w | output | 1 | 3-wire read enable |
| clk_div | output | 16 | Clock divider value |
| xfer_len | output | 16 | Transfer length in bytes |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones that depend on the engine side running against the bus side: DONE and the done interrupt need TA, an empty TX FIFO and an idle engine all at once, and the RX-full and needs-reading thresholds need the engine to outrun the reads. The bench drives the engine inputs itself. Directed steps fill each FIFO past its limit, switch TA with and without queued data, and flush while data is queued. A seeded random phase then interleaves bus pushes, engine pops, engine pushes, bus pops, TA changes and idle changes, and checks every data byte and every status read against queue models in the bench.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_FIFO = 3'd1,
    RG_CDIV = 3'd2,
    RG_DLEN = 3'd3,
    RG_HOLD = 3'd4,
    RG_DMAC = 3'd5
  } reg_sel_e;

  localparam int unsigned B_TXCLR = 4;
  localparam int unsigned B_RXCLR = 5;
  localparam int unsigned B_TA    = 7;
  localparam int unsigned B_INTD  = 9;
  localparam int unsigned B_INTR  = 10;

  function automatic reg_sel_e word_of(input logic [4:0] addr);
    return reg_sel_e'(addr[4:2]);
  endfunction

  function automatic logic at_or_above(input int unsigned cnt, input int unsigned lvl);
    return cnt >= lvl;
  endfunction
endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [WIDTH-1:0]               din,
  input  logic                           pop,
  output logic [WIDTH-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           empty,
  output logic                           full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_step(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_step(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> count == CW'(DEPTH)); // R4
  AST_EMPTY_POP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !flush |=> empty); // R5
endmodule

// File: rtl/spi_rf_status.sv
module spi_rf_status #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned RXR_LEVEL = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ta,
  input  logic                       en_done_irq,
  input  logic                       en_rx_irq,
  input  logic                       eng_idle,
  input  logic [$clog2(DEPTH+1)-1:0] tx_count,
  input  logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       fl_done,
  output logic                       fl_rxd,
  output logic                       fl_txd,
  output logic                       fl_rxr,
  output logic                       fl_rxf,
  output logic                       irq
);
  import spi_regfront_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  assign fl_done = ta & (tx_count == '0) & eng_idle;
  assign fl_rxd  = (rx_count != '0);
  assign fl_txd  = (tx_count != CW'(DEPTH));
  assign fl_rxr  = at_or_above(int'(rx_count), RXR_LEVEL);
  assign fl_rxf  = (rx_count == CW'(DEPTH));
  assign irq     = (en_done_irq & fl_done) | (en_rx_irq & fl_rxr);

  AST_FULL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rxf |-> fl_rxr && fl_rxd); // R6
  AST_DONE_NO_TX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fl_done |-> fl_txd); // R7
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned RXR_LEVEL = 12,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [4:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic             req_ready,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic [7:0]       eng_tx_data,
  output logic             eng_tx_valid,
  input  logic             eng_tx_pop,
  input  logic [7:0]       eng_rx_data,
  input  logic             eng_rx_push,
  input  logic             eng_idle,
  output logic             xfer_active,
  output logic             clk_pol,
  output logic             clk_pha,
  output logic [1:0]       cs_sel,
  output logic             cs_act_high,
  output logic [2:0]       cs_line_pol,
  output logic             rd_enable_3w,
  output logic [LEN_W-1:0] clk_div,
  output logic [LEN_W-1:0] xfer_len,
  output logic             irq
);
  import spi_regfront_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [13:0]      ctrl_q;
  logic [4:0]       ext_q;
  logic [LEN_W-1:0] cdiv_q, dlen_q, hold_q;
  logic [31:0]      dmac_q;
  logic             rd_valid_q;
  logic [31:0]      rd_data_q, rd_mux;

  logic     wr_ev, rd_ev;
  reg_sel_e sel;
  logic     tx_push, tx_flush, tx_pop, rx_pop, rx_flush;
  logic [7:0]    tx_head, rx_head;
  logic [CW-1:0] tx_count, rx_count;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic fl_done, fl_rxd, fl_txd, fl_rxr, fl_rxf;

  assign req_ready = 1'b1;
  assign wr_ev     = req_valid & req_write;
  assign rd_ev     = req_valid & ~req_write;
  assign sel       = word_of(req_addr);
  assign tx_push   = wr_ev & (sel == RG_FIFO);
  assign rx_pop    = rd_ev & (sel == RG_FIFO);
  assign tx_flush  = wr_ev & (sel == RG_CTRL) & req_wdata[B_TXCLR];
  assign rx_flush  = wr_ev & (sel == RG_CTRL) & req_wdata[B_RXCLR];
  assign tx_pop    = eng_tx_pop & ctrl_q[B_TA];

  spi_rf_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push),
    .din(req_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
    .count(tx_count), .empty(tx_empty), .full(tx_full));

  spi_rf_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(eng_rx_push),
    .din(eng_rx_data), .pop(rx_pop), .dout(rx_head),
    .count(rx_count), .empty(rx_empty), .full(rx_full));

  spi_rf_status #(.DEPTH(DEPTH), .RXR_LEVEL(RXR_LEVEL)) u_stat (
    .clk(clk), .rst_n(rst_n), .ta(ctrl_q[B_TA]),
    .en_done_irq(ctrl_q[B_INTD]), .en_rx_irq(ctrl_q[B_INTR]),
    .eng_idle(eng_idle), .tx_count(tx_count), .rx_count(rx_count),
    .fl_done(fl_done), .fl_rxd(fl_rxd), .fl_txd(fl_txd),
    .fl_rxr(fl_rxr), .fl_rxf(fl_rxf), .irq(irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ext_q  <= '0;
      cdiv_q <= '0;
      dlen_q <= '0;
      hold_q <= '0;
      dmac_q <= '0;
    end else if (wr_ev) begin
      case (sel)
        RG_CTRL: begin
          ctrl_q <= {req_wdata[13:6], 2'b00, req_wdata[3:0]};
          ext_q  <= req_wdata[25:21];
        end
        RG_CDIV: cdiv_q <= req_wdata[LEN_W-1:0];
        RG_DLEN: dlen_q <= req_wdata[LEN_W-1:0];
        RG_HOLD: hold_q <= req_wdata[LEN_W-1:0];
        RG_DMAC: dmac_q <= req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      RG_CTRL: rd_mux = {6'b0, ext_q, fl_rxf, fl_rxr, fl_txd, fl_rxd, fl_done,
                         2'b00, ctrl_q};
      RG_FIFO: rd_mux = {24'b0, rx_head};
      RG_CDIV: rd_mux = 32'(cdiv_q);
      RG_DLEN: rd_mux = 32'(dlen_q);
      RG_HOLD: rd_mux = 32'(hold_q);
      RG_DMAC: rd_mux = dmac_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_ev;
      if (rd_ev) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid     = rd_valid_q;
  assign rd_data      = rd_data_q;
  assign eng_tx_data  = tx_head;
  assign eng_tx_valid = ~tx_empty;
  assign cs_sel       = ctrl_q[1:0];
  assign clk_pha      = ctrl_q[2];
  assign clk_pol      = ctrl_q[3];
  assign cs_act_high  = ctrl_q[6];
  assign xfer_active  = ctrl_q[B_TA];
  assign rd_enable_3w = ctrl_q[12];
  assign cs_line_pol  = ext_q[2:0];
  assign clk_div      = cdiv_q;
  assign xfer_len     = dlen_q;

  AST_TX_FROZEN_NO_TA: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active && !tx_push && !tx_flush |=> $stable(tx_count)); // R9
  AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_empty); // R3
  AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_empty); // R3
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && rx_empty |=> rd_data[7:0] == 8'h00); // R5
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> rd_valid); // R11
  AST_DONE_IRQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) && tx_empty && eng_idle && ctrl_q[B_INTD] |-> irq); // R8
endmodule

// File: tb/sim_spi_regfront.sv
module sim_spi_regfront;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [4:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  eng_tx_data, eng_rx_data = 0;
  logic        eng_tx_valid, eng_tx_pop = 0, eng_rx_push = 0, eng_idle = 1;
  logic        xfer_active, clk_pol, clk_pha, cs_act_high, rd_enable_3w, irq;
  logic [1:0]  cs_sel;
  logic [2:0]  cs_line_pol;
  logic [15:0] clk_div, xfer_len;

  spi_regfront u0 (.*);

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit m_ta = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input bit ta, input int txn, input int rxn, input bit idle);
    logic [31:0] s = 32'h0;
    s[16] = ta && txn == 0 && idle;
    s[17] = rxn > 0;
    s[18] = txn < 16;
    s[19] = rxn >= 12;
    s[20] = rxn == 16;
    return s;
  endfunction

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rd_data;
    checks++;
    if (rd_valid !== 1'b1) begin errors++; $display("FAIL R11 rd_valid act=%b exp=1", rd_valid); end
  endtask

  task automatic push_tx(input logic [7:0] b);
    bus_wr(5'h04, {24'hABCDEF, b});
    if (txq.size() < 16) txq.push_back(b);
  endtask

  task automatic eng_pop();
    eng_tx_pop = 1;
    @(negedge clk);
    eng_tx_pop = 0;
    if (m_ta && txq.size() > 0) void'(txq.pop_front());
  endtask

  task automatic eng_push(input logic [7:0] b);
    eng_rx_data = b; eng_rx_push = 1;
    @(negedge clk);
    eng_rx_push = 0;
    if (rxq.size() < 16) rxq.push_back(b);
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    bus_wr(5'h00, v);
    m_ta = v[7];
    if (v[4]) txq.delete();
    if (v[5]) rxq.delete();
  endtask

  task automatic chk_status(input string tag, input logic [31:0] ctrl_bits);
    logic [31:0] d;
    bus_rd(5'h00, d);
    chk(tag, d, ctrl_bits | exp_stat(m_ta, txq.size(), rxq.size(), eng_idle));
  endtask

  task automatic pop_rx_chk(input string tag);
    logic [31:0] d;
    logic [7:0] e;
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
    bus_rd(5'h04, d);
    chk(tag, d, {24'h0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_rd(5'h00, d);
    chk("R1 ctrl/status after reset", d, 32'h0004_0000);
    chk("R1 irq low", {31'b0, irq}, 0);
    chk("R1 tx empty", {31'b0, eng_tx_valid}, 0);
    chk("R11 ready", {31'b0, req_ready}, 1);

    // R2 control layout, R7 done, R8 done irq at TA start
    eng_idle = 1;
    set_ctrl(32'h03E0_3FCF);
    chk("R8 irq at TA start", {31'b0, irq}, 1);
    bus_rd(5'h00, d);
    chk("R2 R7 ctrl readback", d, 32'h03E5_3FCF);
    chk("R2 outputs", {cs_sel, clk_pha, clk_pol, cs_act_high, xfer_active, rd_enable_3w, cs_line_pol},
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'b111});
    set_ctrl(32'h0000_0030);
    bus_rd(5'h00, d);
    chk("R2 clear bits not stored", d, 32'h0004_0000);
    chk("R8 irq low", {31'b0, irq}, 0);

    // R10 data registers, R11 unmapped
    bus_wr(5'h08, 32'hFFFF_1234); bus_rd(5'h08, d); chk("R10 divider", d, 32'h0000_1234);
    chk("R10 clk_div port", {16'h0, clk_div}, 32'h1234);
    bus_wr(5'h0C, 32'hABCD_FFFF); bus_rd(5'h0C, d); chk("R10 length max", d, 32'h0000_FFFF);
    chk("R10 xfer_len port", {16'h0, xfer_len}, 32'hFFFF);
    bus_wr(5'h10, 32'h0001_00AA); bus_rd(5'h10, d); chk("R10 hold", d, 32'h0000_00AA);
    bus_wr(5'h14, 32'hDEAD_BEEF); bus_rd(5'h14, d); chk("R10 dma word", d, 32'hDEAD_BEEF);
    bus_rd(5'h18, d); chk("R11 unmapped", d, 32'h0);

    // R4 fill TX past full, R9 no pop without TA
    for (int i = 0; i < 17; i++) push_tx(8'($urandom));
    chk_status("R4 R6 tx full status", 32'h0);
    chk("R4 head", {24'h0, eng_tx_data}, {24'h0, txq[0]});
    eng_pop();
    chk("R9 pop ignored without TA", {24'h0, eng_tx_data}, {24'h0, txq[0]});
    eng_idle = 0;
    set_ctrl(32'h0000_0080);
    chk_status("R7 busy no done", 32'h80);
    for (int i = 0; i < 16; i++) begin
      chk("R4 tx order", {24'h0, eng_tx_data}, {24'h0, txq[0]});
      eng_pop();
    end
    chk("R4 tx drained", {31'b0, eng_tx_valid}, 0);
    chk_status("R7 engine busy", 32'h80);
    eng_idle = 1;
    @(negedge clk);
    chk_status("R7 done", 32'h80);
    set_ctrl(32'h0000_0280);
    chk("R8 done irq", {31'b0, irq}, 1);
    push_tx(8'h5A); push_tx(8'hA5);
    chk("R8 irq drops with data", {31'b0, irq}, 0);
    set_ctrl(32'h0);
    chk_status("R9 TA clear keeps tx", 32'h0);
    set_ctrl(32'h80);
    chk("R9 head kept", {24'h0, eng_tx_data}, 32'h5A);
    eng_pop(); eng_pop();
    set_ctrl(32'h0);

    // R5 R6 RX thresholds, R8 rx irq
    set_ctrl(32'h0000_0400);
    for (int i = 0; i < 11; i++) eng_push(8'($urandom));
    chk_status("R6 eleven bytes", 32'h400);
    chk("R8 no rx irq at 11", {31'b0, irq}, 0);
    eng_push(8'($urandom));
    chk_status("R6 needs reading at 12", 32'h400);
    chk("R8 rx irq at 12", {31'b0, irq}, 1);
    for (int i = 0; i < 8; i++) eng_push(8'($urandom));
    chk_status("R5 R6 rx full, extras dropped", 32'h400);
    for (int i = 0; i < 16; i++) pop_rx_chk("R5 rx order");
    pop_rx_chk("R5 empty read zero");
    chk_status("R5 empty pop no change", 32'h400);

    // R3 flushes
    set_ctrl(32'h0);
    for (int i = 0; i < 5; i++) begin push_tx(8'(i + 1)); eng_push(8'(i + 9)); end
    set_ctrl(32'h10);
    chk("R3 tx flushed", {31'b0, eng_tx_valid}, 0);
    chk_status("R3 rx kept", 32'h0);
    set_ctrl(32'h20);
    chk_status("R3 rx flushed", 32'h0);
    pop_rx_chk("R3 flushed rx reads zero");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      op = $urandom_range(0, 6);
      case (op)
        0: push_tx(8'($urandom));
        1: begin
             if (m_ta && txq.size() > 0)
               chk("R4 random tx data", {24'h0, eng_tx_data}, {24'h0, txq[0]});
             eng_pop();
           end
        2: eng_push(8'($urandom));
        3: pop_rx_chk("R5 random rx data");
        4: set_ctrl({24'h0, 1'($urandom), 7'h0});
        5: begin eng_idle = 1'($urandom); @(negedge clk); end
        default: chk_status("R6 R7 random status", m_ta ? 32'h80 : 32'h0);
      endcase
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule